// File: doc/BRIEF.md
# Transmit/Receive Byte Queue Pair with Level Thresholds

This block sits between a register bus and a two-wire serial transfer engine. It holds two independent byte queues. The host stores outgoing bytes in the transmit queue, and the engine drains that queue as it shifts bytes onto the wire. The engine stores incoming bytes in the receive queue, and the host collects them. Each queue holds 128 one-byte entries and presents its oldest entry combinationally on its read port.

A control word, written with a single strobe, loads an upper threshold and a lower threshold. One bit of the same word empties both queues. The receive upper threshold is meant to be rewritten between host drains. The software sets it to the number of bytes still expected, so the high-level flag fires at the moment the last awaited byte lands. The lower threshold gives a refill point for the transmit queue.

Both fill levels come out on one packed count word. Empty, full and level flags, together with sticky overflow and underflow bits, feed the interrupt logic next to the block.

Top module: `i2cf_fifo_pair`

## Requirements
- R1: After reset both queues are empty: `count_o` = 0, `tx_empty_o` = `rx_empty_o` = 1, both full flags 0, `err_o` = 0, `rx_high_o` = 0, `tx_low_o` = 1, both thresholds 0.
- R2: Each queue returns bytes in the order they were stored. The read port (`eng_tx_data_o`, `rx_rdata_o`) shows the oldest entry before it is popped.
- R3: A queue holding 128 entries raises its full flag. A push to a full queue with no pop in the same cycle is dropped, leaves the contents unchanged and sets a sticky overflow bit (`err_o[0]` transmit, `err_o[2]` receive).
- R4: A pop from an empty queue returns 0 on the read port, leaves the count at 0 and sets a sticky underflow bit (`err_o[1]` transmit, `err_o[3]` receive). Overflow and underflow bits stay set until an emptying write.
- R5: A push and a pop in the same cycle on a non-empty queue leave its count unchanged, including when the queue is full. On an empty queue the pop counts as an underflow and the push is stored.
- R6: `count_o[7:0]` is the receive fill level and `count_o[15:8]` is the transmit fill level (0..128).
- R7: A control write loads the upper threshold from bits [15:8] and the lower threshold from bits [7:0]. `rx_high_o` is 1 while the upper threshold is non-zero and the receive level is at or above it. A threshold of 0 keeps the flag at 0.
- R8: `tx_low_o` is 1 while the transmit level is at or below the lower threshold.
- R9: A control write with bit 16 set empties both queues and clears all four sticky bits on that edge, ahead of any push or pop in the same cycle. The thresholds in that word are still loaded. Without bit 16, no queue contents change.
- R10: A threshold rewrite takes effect on the cycle after the write, with the queue contents untouched, so `rx_high_o` follows the new value immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Host push strobe, transmit queue |
| tx_wdata_i | input | 8 | Host byte to transmit |
| rx_rd_i | input | 1 | Host pop strobe, receive queue |
| rx_rdata_o | output | 8 | Oldest received byte, 0 when empty |
| eng_tx_pop_i | input | 1 | Engine pop strobe, transmit queue |
| eng_tx_data_o | output | 8 | Oldest byte to transmit, 0 when empty |
| eng_rx_push_i | input | 1 | Engine push strobe, receive queue |
| eng_rx_data_i | input | 8 | Byte received by the engine |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word: [16] empty both, [15:8] upper, [7:0] lower threshold |
| count_o | output | 16 | {transmit level, receive level} |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue full |
| tx_low_o | output | 1 | Transmit level at or below lower threshold |
| rx_high_o | output | 1 | Receive level at or above non-zero upper threshold |
| err_o | output | 4 | Sticky {rx underflow, rx overflow, tx underflow, tx overflow} |

## Verification
Short sequences of distinct bytes tell correct ordering apart from pointer or wrap mistakes. A full 128-entry fill followed by one extra byte shows whether the full boundary drops the write or corrupts the oldest entry. Simultaneous push and pop, tried on a partly filled, a full and an empty queue, tells the count bookkeeping apart at each edge case. Receive threshold rewrites around a fixed fill level, including a rewrite to zero, tell a live comparison apart from a stale or latched flag. An emptying write issued with a concurrent push shows that emptying takes priority.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  localparam int unsigned CTL_FLUSH_BIT = 16;
  localparam int unsigned THR_W         = 8;
  localparam int unsigned CTL_HI_LSB    = 8;
  localparam int unsigned CTL_LO_LSB    = 0;

  typedef struct packed {
    logic rx_udf;
    logic rx_ovf;
    logic tx_udf;
    logic tx_ovf;
  } err_t;
endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          udf_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q, udf_q;
  logic          wr_ok, rd_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_MAX);
  // full implies non-empty, so a pop frees the slot this push needs
  assign wr_ok   = push_i & (~full_o | pop_i);
  assign rd_ok   = pop_i & ~empty_o;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == PTR_MAX) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_ok && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (wr_ok) wp_q <= ptr_inc(wp_q);
      if (rd_ok) rp_q <= ptr_inc(rp_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && !wr_ok) ovf_q <= 1'b1;
      if (pop_i && !rd_ok)  udf_q <= 1'b1;
    end
  end

  assign rdata_o = empty_o ? '0 : mem_q[rp_q];
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign udf_o   = udf_q;
endmodule

// File: rtl/i2cf_ctl.sv
module i2cf_ctl
  import i2cf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic [31:0]      ctl_wdata_i,
  output logic             flush_o,
  output logic [THR_W-1:0] thr_hi_o,
  output logic [THR_W-1:0] thr_lo_o
);
  logic [THR_W-1:0] hi_q, lo_q;

  // self-clearing: the emptying bit acts only on the write edge
  assign flush_o = ctl_wr_i & ctl_wdata_i[CTL_FLUSH_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (ctl_wr_i) begin
      hi_q <= ctl_wdata_i[CTL_HI_LSB +: THR_W];
      lo_q <= ctl_wdata_i[CTL_LO_LSB +: THR_W];
    end
  end

  assign thr_hi_o = hi_q;
  assign thr_lo_o = lo_q;
endmodule

// File: rtl/i2cf_levels.sv
module i2cf_levels #(
  parameter int unsigned CW    = 8,
  parameter int unsigned THR_W = 8,
  localparam int unsigned MW   = (CW > THR_W) ? CW : THR_W
) (
  input  logic [CW-1:0]    tx_cnt_i,
  input  logic [CW-1:0]    rx_cnt_i,
  input  logic [THR_W-1:0] thr_hi_i,
  input  logic [THR_W-1:0] thr_lo_i,
  output logic             tx_low_o,
  output logic             rx_high_o
);
  logic [MW-1:0] tx_w, rx_w, hi_w, lo_w;

  assign tx_w = MW'(tx_cnt_i);
  assign rx_w = MW'(rx_cnt_i);
  assign hi_w = MW'(thr_hi_i);
  assign lo_w = MW'(thr_lo_i);

  assign rx_high_o = (hi_w != '0) && (rx_w >= hi_w);
  assign tx_low_o  = (tx_w <= lo_w);
endmodule

// File: rtl/i2cf_fifo_pair.sv
module i2cf_fifo_pair
  import i2cf_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] tx_wdata_i,
  input  logic          rx_rd_i,
  output logic [DW-1:0] rx_rdata_o,
  input  logic          eng_tx_pop_i,
  output logic [DW-1:0] eng_tx_data_o,
  input  logic          eng_rx_push_i,
  input  logic [DW-1:0] eng_rx_data_i,
  input  logic          ctl_wr_i,
  input  logic [31:0]   ctl_wdata_i,
  output logic [2*CW-1:0] count_o,
  output logic          tx_empty_o,
  output logic          tx_full_o,
  output logic          rx_empty_o,
  output logic          rx_full_o,
  output logic          tx_low_o,
  output logic          rx_high_o,
  output logic [3:0]    err_o
);
  logic             flush;
  logic [THR_W-1:0] thr_hi, thr_lo;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  err_t             err;

  i2cf_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_wdata_i (ctl_wdata_i),
    .flush_o     (flush),
    .thr_hi_o    (thr_hi),
    .thr_lo_o    (thr_lo)
  );

  i2cf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (tx_wr_i),
    .wdata_i (tx_wdata_i),
    .pop_i   (eng_tx_pop_i),
    .rdata_o (eng_tx_data_o),
    .count_o (tx_cnt),
    .empty_o (tx_empty_o),
    .full_o  (tx_full_o),
    .ovf_o   (err.tx_ovf),
    .udf_o   (err.tx_udf)
  );

  i2cf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (eng_rx_push_i),
    .wdata_i (eng_rx_data_i),
    .pop_i   (rx_rd_i),
    .rdata_o (rx_rdata_o),
    .count_o (rx_cnt),
    .empty_o (rx_empty_o),
    .full_o  (rx_full_o),
    .ovf_o   (err.rx_ovf),
    .udf_o   (err.rx_udf)
  );

  i2cf_levels #(.CW(CW), .THR_W(THR_W)) u_lvl (
    .tx_cnt_i  (tx_cnt),
    .rx_cnt_i  (rx_cnt),
    .thr_hi_i  (thr_hi),
    .thr_lo_i  (thr_lo),
    .tx_low_o  (tx_low_o),
    .rx_high_o (rx_high_o)
  );

  assign count_o = {tx_cnt, rx_cnt};
  assign err_o   = err;
endmodule

// File: rtl/i2cf_fifo_pair_chk.sv
module i2cf_fifo_pair_chk #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tx_wr_i,
  input logic            rx_rd_i,
  input logic [7:0]      rx_rdata_o,
  input logic            eng_tx_pop_i,
  input logic            ctl_wr_i,
  input logic [31:0]     ctl_wdata_i,
  input logic [2*CW-1:0] count_o,
  input logic            tx_empty_o,
  input logic            tx_full_o,
  input logic            rx_empty_o,
  input logic            rx_high_o,
  input logic [3:0]      err_o
);
  logic          flush_w;
  logic [CW-1:0] tx_cnt_w;
  assign flush_w  = ctl_wr_i & ctl_wdata_i[16];
  assign tx_cnt_w = count_o[2*CW-1:CW];

  p_tx_cnt_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_w <= CW'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && tx_full_o && !eng_tx_pop_i && !flush_w) |=> (tx_full_o && err_o[0]));

  p_empty_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> (rx_rdata_o == 8'h00));

  p_udf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o[1] && !flush_w) |=> err_o[1]);

  p_same_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && eng_tx_pop_i && !tx_empty_o && !flush_w) |=> $stable(tx_cnt_w));

  p_high_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_high_o && !rx_rd_i && !ctl_wr_i) |=> rx_high_o);

  p_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_w |=> (count_o == '0 && err_o == 4'h0 && tx_empty_o));
endmodule

bind i2cf_fifo_pair i2cf_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_wr_i      (tx_wr_i),
  .rx_rd_i      (rx_rd_i),
  .rx_rdata_o   (rx_rdata_o),
  .eng_tx_pop_i (eng_tx_pop_i),
  .ctl_wr_i     (ctl_wr_i),
  .ctl_wdata_i  (ctl_wdata_i),
  .count_o      (count_o),
  .tx_empty_o   (tx_empty_o),
  .tx_full_o    (tx_full_o),
  .rx_empty_o   (rx_empty_o),
  .rx_high_o    (rx_high_o),
  .err_o        (err_o)
);

// File: tb/i2cf_fifo_pair_bench.sv
`timescale 1ns/1ps
module i2cf_fifo_pair_bench;
  logic        clk, rst_n;
  logic        tx_wr, rx_rd, tx_pop, rx_push, ctl_wr;
  logic [7:0]  tx_wdata, rx_rdata, tx_data, rx_wdata;
  logic [31:0] ctl_wdata;
  logic [15:0] count;
  logic        tx_empty, tx_full, rx_empty, rx_full, tx_low, rx_high;
  logic [3:0]  err;
  int          n_chk = 0, n_fail = 0;

  i2cf_fifo_pair u_i2cf_fifo_pair (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata),
    .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata),
    .eng_tx_pop_i(tx_pop), .eng_tx_data_o(tx_data),
    .eng_rx_push_i(rx_push), .eng_rx_data_i(rx_wdata),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .count_o(count), .tx_empty_o(tx_empty), .tx_full_o(tx_full),
    .rx_empty_o(rx_empty), .rx_full_o(rx_full),
    .tx_low_o(tx_low), .rx_high_o(rx_high), .err_o(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic twr, input logic [7:0] td, input logic rrd,
                      input logic tpop, input logic rpush, input logic [7:0] rd);
    tx_wr = twr; tx_wdata = td; rx_rd = rrd; tx_pop = tpop; rx_push = rpush; rx_wdata = rd;
    @(posedge clk);
    @(negedge clk);
    tx_wr = 0; rx_rd = 0; tx_pop = 0; rx_push = 0;
  endtask

  task automatic ctl(input logic [31:0] w);
    ctl_wr = 1; ctl_wdata = w;
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 full flags", {tx_full, rx_full}, 0);
    chk("R1 err", err, 0);
    chk("R1 rx_high", rx_high, 0);
    chk("R1 tx_low", tx_low, 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0);
    chk("R6 tx level", count[15:8], 5);
    chk("R6 rx level", count[7:0], 0);
    for (int i = 0; i < 5; i++) begin
      chk("R2 tx order", tx_data, 8'h10 + 8'(i));
      step(0, 0, 0, 1, 0, 0);
    end
    chk("R2 tx drained", tx_empty, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 8'hC0 + 8'(i));
    chk("R6 rx level 3", count[7:0], 3);
    for (int i = 0; i < 3; i++) begin
      chk("R2 rx order", rx_rdata, 8'hC0 + 8'(i));
      step(0, 0, 1, 0, 0, 0);
    end
    chk("R2 rx drained", rx_empty, 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < 128; i++) step(1, 8'(i) ^ 8'h5A, 0, 0, 0, 0);
    chk("R3 full flag", tx_full, 1);
    chk("R3 level 128", count[15:8], 128);
    chk("R3 no err yet", err, 0);
    step(1, 8'hEE, 0, 0, 0, 0);
    chk("R3 level kept", count[15:8], 128);
    chk("R3 overflow bit", err[0], 1);
    for (int i = 0; i < 128; i++) begin
      if (tx_data !== (8'(i) ^ 8'h5A)) chk("R3 content", tx_data, 8'(i) ^ 8'h5A);
      step(0, 0, 0, 1, 0, 0);
    end
    chk("R3 drained", {tx_empty, tx_full}, 2'b10);
    chk("R4 overflow sticky", err[0], 1);
    ctl(32'h0001_0000);
  endtask

  task automatic t_underflow();
    chk("R4 rx read zero", rx_rdata, 0);
    step(0, 0, 1, 0, 0, 0);
    chk("R4 rx level 0", count[7:0], 0);
    chk("R4 rx underflow", err[3], 1);
    chk("R4 tx data zero", tx_data, 0);
    step(0, 0, 0, 1, 0, 0);
    chk("R4 tx underflow", err[1], 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R4 sticky", err, 4'b1010);
    ctl(32'h0000_0000);
    chk("R9 no flush without bit", err, 4'b1010);
    ctl(32'h0001_0000);
    chk("R9 sticky cleared", err, 0);
  endtask

  task automatic t_simul();
    for (int i = 0; i < 3; i++) step(1, 8'h30 + 8'(i), 0, 0, 0, 0);
    step(1, 8'h33, 0, 1, 0, 0);
    chk("R5 level same", count[15:8], 3);
    chk("R5 head advanced", tx_data, 8'h31);
    for (int i = 0; i < 125; i++) step(1, 8'h40, 0, 0, 0, 0);
    chk("R5 full", tx_full, 1);
    step(1, 8'h77, 0, 1, 0, 0);
    chk("R5 full level same", count[15:8], 128);
    chk("R5 full no overflow", err[0], 0);
    chk("R5 head after full pop", tx_data, 8'h32);
    step(0, 0, 1, 0, 1, 8'h99);
    chk("R5 empty push stored", count[7:0], 1);
    chk("R5 empty pop underflow", err[3], 1);
    chk("R5 stored byte", rx_rdata, 8'h99);
    ctl(32'h0001_0000);
  endtask

  task automatic t_thresh();
    ctl(32'h0001_0402);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 8'(i));
    chk("R7 below hi", rx_high, 0);
    step(0, 0, 0, 0, 1, 8'h03);
    chk("R7 at hi", rx_high, 1);
    step(1, 8'h01, 0, 0, 0, 0);
    step(1, 8'h02, 0, 0, 0, 0);
    chk("R8 tx at lo", tx_low, 1);
    step(1, 8'h03, 0, 0, 0, 0);
    chk("R8 tx above lo", tx_low, 0);
    ctl(32'h0000_0602);
    chk("R10 new hi clears", rx_high, 0);
    chk("R10 contents kept", count, 16'h0304);
    step(0, 0, 0, 0, 1, 8'h04);
    step(0, 0, 0, 0, 1, 8'h05);
    chk("R10 reaches new hi", rx_high, 1);
    step(0, 0, 1, 0, 0, 0);
    chk("R7 drops below", rx_high, 0);
    ctl(32'h0000_0002);
    chk("R7 zero disables", rx_high, 0);
    chk("R7 level held", count[7:0], 5);
  endtask

  task automatic t_flush();
    tx_wr = 1; tx_wdata = 8'hAB; tx_pop = 1; rx_push = 1; rx_wdata = 8'hCD;
    ctl(32'h0001_0000);
    tx_wr = 0; tx_pop = 0; rx_push = 0;
    chk("R9 counts zero", count, 0);
    chk("R9 empties", {tx_empty, rx_empty}, 2'b11);
    chk("R9 thresholds loaded", tx_low, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; tx_wr = 0; rx_rd = 0; tx_pop = 0; rx_push = 0; ctl_wr = 0;
    tx_wdata = 0; rx_wdata = 0; ctl_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_underflow();
    t_simul();
    t_thresh();
    t_flush();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule